// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves an address translation that missed in the translation buffer. It walks a two-level page table held in memory. A miss request brings a virtual address and a context tag. The walker reads the first-level entry from the table whose base comes from the root base input. If that entry is present, its upper bits give the base of the second-level table, and the walker reads the leaf entry from there. A present leaf produces a one-cycle fill toward the translation buffer and a retry pulse toward the requester, which repeats its access and is expected to hit. An absent entry at either level produces a one-cycle page-fault pulse that carries the faulting virtual address.

The memory port is a plain request/response pair with one read in flight at a time. The response may arrive any number of cycles after the request. With the default parameters, a virtual address has 10 bits of first-level index, 10 bits of second-level index and 12 bits of page offset. Table entries are 32 bits wide, with bit 0 as the present flag and bits 31:12 as the frame or the next table base. A flush during a read or wait step drops the walk, and the requester must issue the miss again.

Top module: `pt_walker`

## Requirements
- R1: While reset is held and in the first cycle after it, busy, mem_req_valid, fill_valid, fault_valid and retry are all low.
- R2: A miss_valid seen while busy is low starts a walk, and busy is high in the next cycle. miss_valid while busy is high is ignored: the walk in progress keeps its original address and context.
- R3: The first read address is root_base + VA[31:22] × 4.
- R4: The second read address is {first entry bits 31:12, 12'b0} + VA[21:12] × 4.
- R5: mem_req_valid lasts exactly one cycle, and no new request is issued until the response to the previous one has arrived.
- R6: If bit 0 of the first-level entry is 0, fault_valid pulses for one cycle with fault_va equal to the miss address. No second read is made, and no fill occurs.
- R7: If bit 0 of the second-level entry is 0, fault_valid pulses for one cycle with fault_va equal to the miss address, and no fill occurs.
- R8: If the second-level entry has bit 0 set, fill_valid and retry pulse together for one cycle with fill_vpn = VA[31:12], fill_pfn = entry bits 31:12, fill_ctx = the miss context, and fill_pa = {fill_pfn, VA[11:0]}.
- R9: The cycle after a fill or fault pulse, busy is low.
- R10: flush while the walker is in a read or wait step ends the walk: busy is low next cycle, no further read is issued, no fill or fault follows, and a late response is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| root_base | input | 32 | Physical base of the first-level table |
| miss_valid | input | 1 | Translation miss request |
| miss_va | input | 32 | Virtual address that missed |
| miss_ctx | input | CTX_W | Context tag of the access |
| flush | input | 1 | Abort an in-progress walk |
| busy | output | 1 | Walk in progress; new misses are not taken |
| mem_req_valid | output | 1 | Memory read request, one cycle |
| mem_req_addr | output | 32 | Address of the entry to read |
| mem_resp_valid | input | 1 | Read data valid |
| mem_resp_data | input | 32 | Table entry read from memory |
| fill_valid | output | 1 | Install translation into the buffer |
| fill_vpn | output | 20 | Virtual page number to install |
| fill_pfn | output | 20 | Physical frame number to install |
| fill_ctx | output | CTX_W | Context tag to install |
| fill_pa | output | 32 | Translated physical address of the miss |
| retry | output | 1 | Requester should repeat its access |
| fault_valid | output | 1 | Page fault |
| fault_va | output | 32 | Faulting virtual address |

## Verification
The bench sweeps first-level indices across present and absent entries, second-level indices including 0 and 1023, offsets 0 and 0xFFF, and memory latencies of 1 to 4 cycles. It checks every read address and the count of reads. A walker that kept reading after a first-level fault would show a second request. One that took the frame from the wrong entry, or mixed up the two index fields, would show a wrong fill_pa or wrong request addresses. A miss presented during every walk would corrupt the result of a walker that did not ignore it. Flushes in both wait steps, followed by a late response, expose a walker that completes, faults or reads again after an abort.

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int CTX_W = 8,
  parameter int L1_W  = 10,
  parameter int L2_W  = 10,
  parameter int OFF_W = 12
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [31:0]                   root_base,
  input  logic                          miss_valid,
  input  logic [L1_W+L2_W+OFF_W-1:0]    miss_va,
  input  logic [CTX_W-1:0]              miss_ctx,
  input  logic                          flush,
  output logic                          busy,
  output logic                          mem_req_valid,
  output logic [31:0]                   mem_req_addr,
  input  logic                          mem_resp_valid,
  input  logic [31:0]                   mem_resp_data,
  output logic                          fill_valid,
  output logic [L1_W+L2_W-1:0]          fill_vpn,
  output logic [31-OFF_W:0]             fill_pfn,
  output logic [CTX_W-1:0]              fill_ctx,
  output logic [31:0]                   fill_pa,
  output logic                          retry,
  output logic                          fault_valid,
  output logic [L1_W+L2_W+OFF_W-1:0]    fault_va
);
  localparam int VA_W  = L1_W + L2_W + OFF_W;
  localparam int PFN_W = 32 - OFF_W;

  typedef enum logic [2:0] {
    S_IDLE, S_READ_L1, S_WAIT_L1, S_READ_L2, S_WAIT_L2, S_FILL, S_FAULT
  } state_t;

  state_t             state;
  logic [VA_W-1:0]    va_q;
  logic [CTX_W-1:0]   ctx_q;
  logic [PFN_W-1:0]   base_q;

  wire [L1_W-1:0] idx1 = va_q[VA_W-1 -: L1_W];
  wire [L2_W-1:0] idx2 = va_q[OFF_W +: L2_W];
  wire in_walk = (state == S_READ_L1) || (state == S_WAIT_L1) ||
                 (state == S_READ_L2) || (state == S_WAIT_L2);
  wire abort   = flush && in_walk;
  wire present = mem_resp_data[0];

  logic unused_bits;
  assign unused_bits = ^mem_resp_data[OFF_W-1:1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      va_q   <= '0;
      ctx_q  <= '0;
      base_q <= '0;
    end else if (abort) begin
      state <= S_IDLE;
    end else begin
      case (state)
        S_IDLE: if (miss_valid) begin
          va_q  <= miss_va;
          ctx_q <= miss_ctx;
          state <= S_READ_L1;
        end
        S_READ_L1: state <= S_WAIT_L1;
        S_WAIT_L1: if (mem_resp_valid) begin
          if (present) begin
            base_q <= mem_resp_data[31:OFF_W];
            state  <= S_READ_L2;
          end else state <= S_FAULT;
        end
        S_READ_L2: state <= S_WAIT_L2;
        S_WAIT_L2: if (mem_resp_valid) begin
          if (present) begin
            base_q <= mem_resp_data[31:OFF_W];
            state  <= S_FILL;
          end else state <= S_FAULT;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy          = (state != S_IDLE);
  assign mem_req_valid = ((state == S_READ_L1) || (state == S_READ_L2)) && !flush;
  assign mem_req_addr  = (state == S_READ_L1)
                       ? root_base + {{(30-L1_W){1'b0}}, idx1, 2'b00}
                       : {base_q, {OFF_W{1'b0}}} + {{(30-L2_W){1'b0}}, idx2, 2'b00};
  assign fill_valid    = (state == S_FILL);
  assign retry         = fill_valid;
  assign fill_vpn      = va_q[VA_W-1:OFF_W];
  assign fill_pfn      = base_q;
  assign fill_ctx      = ctx_q;
  assign fill_pa       = {base_q, va_q[OFF_W-1:0]};
  assign fault_valid   = (state == S_FAULT);
  assign fault_va      = va_q;

  assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_valid && !busy) |=> busy);
  assert_req_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |=> !mem_req_valid);
  assert_idle_after_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid || fault_valid) |=> !busy);
  assert_flush_abort_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && flush && !fill_valid && !fault_valid) |=> (!busy && !fill_valid && !fault_valid));
  assert_one_outcome_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid |=> !fill_valid && !fault_valid);
endmodule

// File: tb/test_pt_walker.sv
`timescale 1ns/1ps
module test_pt_walker;
  localparam logic [31:0] ROOT = 32'h0010_0000;

  logic clk = 0, rst_n = 0;
  logic [31:0] root_base = ROOT;
  logic miss_valid = 0, flush = 0;
  logic [31:0] miss_va = '0;
  logic [7:0] miss_ctx = '0;
  logic busy, mem_req_valid, mem_resp_valid = 0;
  logic [31:0] mem_req_addr, mem_resp_data = '0;
  logic fill_valid, retry, fault_valid;
  logic [19:0] fill_vpn, fill_pfn;
  logic [7:0] fill_ctx;
  logic [31:0] fill_pa, fault_va;

  always #2.5 clk = ~clk;

  pt_walker i_pt_walker (
    .clk(clk), .rst_n(rst_n), .root_base(root_base), .miss_valid(miss_valid),
    .miss_va(miss_va), .miss_ctx(miss_ctx), .flush(flush), .busy(busy),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .mem_resp_valid(mem_resp_valid), .mem_resp_data(mem_resp_data),
    .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_pfn(fill_pfn),
    .fill_ctx(fill_ctx), .fill_pa(fill_pa), .retry(retry),
    .fault_valid(fault_valid), .fault_va(fault_va));

  int checks = 0, fails = 0;
  bit done = 0;

  function automatic logic [31:0] mem_fn(input logic [31:0] a);
    logic [29:0] w;
    logic [19:0] fr;
    bit p;
    if (a[31:12] == ROOT[31:12]) begin
      p  = (a[11:2] % 5) != 3;
      fr = 20'h00200 + 20'(a[11:2]);
    end else begin
      w  = a[31:2];
      p  = (w % 7) != 2;
      fr = 20'(w * 13 + 32'h1234);
    end
    return {fr, 11'h0, p};
  endfunction

  int lat = 1, nreq = 0, cnt = 0;
  bit pend = 0, overlap = 0;
  logic [31:0] pend_addr, req_log[4];

  always @(posedge clk) begin
    mem_resp_valid <= 1'b0;
    if (mem_req_valid) begin
      if (pend) overlap <= 1'b1;
      pend <= 1'b1;
      pend_addr <= mem_req_addr;
      cnt <= lat;
      if (nreq < 4) req_log[nreq] <= mem_req_addr;
      nreq <= nreq + 1;
    end else if (pend) begin
      if (cnt <= 1) begin
        mem_resp_valid <= 1'b1;
        mem_resp_data  <= mem_fn(pend_addr);
        pend <= 1'b0;
      end else cnt <= cnt - 1;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic run_walk(input logic [31:0] va, input logic [7:0] ctx, input int l);
    logic [31:0] a1, e1, a2, e2;
    bit f1, f2;
    int wait_n;
    a1 = ROOT + {20'h0, va[31:22], 2'b00};
    e1 = mem_fn(a1);
    f1 = !e1[0];
    a2 = {e1[31:12], 12'h0} + {20'h0, va[21:12], 2'b00};
    e2 = mem_fn(a2);
    f2 = !f1 && !e2[0];
    lat = l;
    @(negedge clk);
    nreq = 0; overlap = 0;
    miss_valid = 1; miss_va = va; miss_ctx = ctx;
    @(negedge clk);
    check(busy == 1, "R2", "busy after accept", busy, 1);
    miss_va = va ^ 32'hFFFF_F0F0; miss_ctx = ~ctx;
    @(negedge clk);
    miss_valid = 0;
    wait_n = 0;
    while (!fill_valid && !fault_valid && wait_n < 100) begin
      @(negedge clk);
      wait_n++;
    end
    check(nreq >= 1 && req_log[0] == a1, "R3", "first read addr", req_log[0], a1);
    check(overlap == 0, "R5", "one read in flight", overlap, 0);
    if (f1) begin
      check(fault_valid && !fill_valid, "R6", "L1 fault pulse", {fault_valid, fill_valid}, 2'b10);
      check(fault_va == va, "R6", "fault va", fault_va, va);
      check(nreq == 1, "R6", "no second read", nreq, 1);
    end else begin
      check(nreq == 2 && req_log[1] == a2, "R4", "second read addr", req_log[1], a2);
      if (f2) begin
        check(fault_valid && !fill_valid, "R7", "L2 fault pulse", {fault_valid, fill_valid}, 2'b10);
        check(fault_va == va, "R7", "fault va", fault_va, va);
      end else begin
        check(fill_valid && retry && !fault_valid, "R8", "fill+retry", {fill_valid, retry, fault_valid}, 3'b110);
        check(fill_vpn == va[31:12], "R8", "fill vpn", fill_vpn, va[31:12]);
        check(fill_pfn == e2[31:12], "R8", "fill pfn", fill_pfn, e2[31:12]);
        check(fill_ctx == ctx, "R8", "fill ctx", fill_ctx, ctx);
        check(fill_pa == {e2[31:12], va[11:0]}, "R8", "fill pa", fill_pa, {e2[31:12], va[11:0]});
      end
    end
    @(negedge clk);
    check(!busy && !fill_valid && !fault_valid && !retry, "R9", "idle after outcome",
          {busy, fill_valid, fault_valid, retry}, 0);
  endtask

  task automatic run_flush(input logic [31:0] va, input int stage);
    int wait_n;
    bit bad;
    lat = 6;
    @(negedge clk);
    nreq = 0;
    miss_valid = 1; miss_va = va; miss_ctx = 8'h5C;
    @(negedge clk);
    miss_valid = 0;
    wait_n = 0;
    while (nreq < stage && wait_n < 50) begin
      @(negedge clk);
      wait_n++;
    end
    flush = 1;
    @(negedge clk);
    flush = 0;
    check(!busy, "R10", "idle after flush", busy, 0);
    bad = 0;
    for (int k = 0; k < 12; k++) begin
      if (fill_valid || fault_valid || busy || mem_req_valid) bad = 1;
      @(negedge clk);
    end
    check(!bad, "R10", "no activity after flush", bad, 0);
    check(nreq == stage, "R10", "no read after flush", nreq, stage);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check({busy, mem_req_valid, fill_valid, fault_valid, retry} == 0, "R1", "outputs in reset",
          {busy, mem_req_valid, fill_valid, fault_valid, retry}, 0);
    rst_n = 1;
    @(negedge clk);
    check({busy, mem_req_valid, fill_valid, fault_valid, retry} == 0, "R1", "outputs after reset",
          {busy, mem_req_valid, fill_valid, fault_valid, retry}, 0);
    for (int i = 0; i < 64; i++) begin
      logic [31:0] va;
      va = {10'(i % 32), 10'((i * 37) % 1024), 12'((i * 291) % 4096)};
      run_walk(va, 8'(i), 1 + (i % 4));
    end
    run_walk({10'd1023, 10'd1023, 12'hFFF}, 8'hFF, 2);
    run_walk({10'd1022, 10'd1023, 12'hFFF}, 8'hA1, 3);
    run_walk({10'd1022, 10'd0, 12'h000}, 8'h01, 1);
    run_walk({10'd0, 10'd0, 12'h000}, 8'h00, 4);
    run_flush({10'd1, 10'd5, 12'h123}, 1);
    run_walk({10'd1, 10'd5, 12'h123}, 8'h5C, 2);
    run_flush({10'd2, 10'd9, 12'h456}, 2);
    run_walk({10'd2, 10'd9, 12'h456}, 8'h5C, 1);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule